// File: doc/BRIEF.md
# Line-Relative Programmable Pulse Generator

This block sits inside an LCD panel timing controller. On each display line it produces one programmable pulse on a general-purpose output. When the panel type needs it, the same pin instead carries the line data-enable signal. The block can also produce a second, single-pixel marker at a programmable delay. A half-pixel counter restarts at every line-start strobe and advances on a clock enable that runs at twice the pixel rate. Both outputs come from comparing that counter against a start value, a stop value and a delay value.

Software sets the five configuration registers through a simple synchronous write port. A combinational read port returns the written values. The block copies the configuration into shadow storage only on a line-start strobe, so a write never disturbs the line already in progress.

The panel-mode code and the preset bits together select one of three behaviours:

- **Digital mode:** an inclusive pixel window.
- **Analog mode:** a half-pixel window with fixed zero-point offsets.
- **Inactive:** both outputs stay low.

Top module: `line_pulse_gen`

## Requirements
- R1: After reset every register reads 0 and both `pulse_out` and `delay_out` are low.
- R2: A write with `reg_we` high stores `reg_wdata` at `reg_addr`. The addresses are 0 start, 1 stop, 2 delay, 3 mode, 4 preset. `reg_rdata` returns the stored value of the addressed register in the same cycle. Addresses 5 to 7 read 0.
- R3: Register writes do not change the outputs of the current line. They take effect from the next cycle in which `line_start` is high.
- R4: In digital mode, `pulse_out` is high exactly when the pixel index p = floor(h/2) satisfies start ≤ p ≤ stop. Here h is the number of `half_tick` pulses since the last line start. The pulse is therefore (stop − start + 1) pixels wide.
- R5: In digital mode with stop < start, `pulse_out` stays low for the whole line.
- R6: Digital mode is active when the low 4 bits of the mode register equal 1010 and preset bit 5 is 1. If either condition is missing, no digital pulse appears.
- R7: Analog mode is active when mode bits 2..0 equal 100 (bit 3 is ignored) and preset bit 7 is 1. In analog mode, `pulse_out` is high exactly when h + 5 ≥ start and h + 2 ≤ stop. Each register step is therefore half a pixel, and start 5 or stop 2 both place their edge at h = 0.
- R8: `delay_out` is high exactly when digital mode is active and floor(h/2) equals the delay register. This makes it one pixel (two half-ticks) wide.
- R9: When neither mode is active, both outputs are low. In analog mode, `delay_out` is low.
- R10: The half-pixel counter saturates at 2^(W+2)−1 (1023 for W=8) and does not wrap, so no pulse repeats late in a long line.
- R11: A cycle with `line_start` high sets h to 0, even if `half_tick` is also high in that cycle. The pulse pattern then restarts from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| half_tick | input | 1 | Enable at twice the pixel rate; advances h |
| line_start | input | 1 | One-cycle line-start strobe; clears h and loads the shadows |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| pulse_out | output | 1 | Primary pulse (general-purpose output or line data-enable) |
| delay_out | output | 1 | Single-pixel delayed marker |

## Verification
The bench runs whole lines against a position-by-position model of h and checks both outputs at every half-pixel step. It uses:

- ordinary, single-pixel, starting-at-zero and reversed windows in digital mode, which separate inclusive from exclusive bounds;
- analog windows around the offset points (start 5 / stop 2, start 0, start 9 / stop 12), which expose wrong offsets or whole-pixel stepping;
- mode codes and preset combinations that miss one enabling condition, which confirm that each gate is required;
- one line long enough to saturate the counter, a mid-line register write, a mid-line restart, and a start coinciding with a tick. These show wrap-around, early shadow loading and the priority of `line_start`.

Ticks arrive both every cycle and every other cycle, so the bench can tell half-tick counting apart from clock counting.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic [2:0] {
    ADR_START  = 3'd0,
    ADR_STOP   = 3'd1,
    ADR_DELAY  = 3'd2,
    ADR_MODE   = 3'd3,
    ADR_PRESET = 3'd4
  } reg_adr_e;

  localparam logic [3:0] MODE_DIGITAL   = 4'b1010;
  localparam logic [2:0] MODE_ANALOG_LO = 3'b100;
  localparam int         PRESET_GP_BIT  = 5;
  localparam int         PRESET_DE_BIT  = 7;
  localparam int         ANA_START_OFS  = 5;
  localparam int         ANA_STOP_OFS   = 2;
  localparam int         NUM_POS_REGS   = 3;

  typedef struct packed {
    logic dig;
    logic ana;
  } mode_t;

endpackage

// File: rtl/lpg_regs.sv
module lpg_regs
  import lpg_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic [REG_W-1:0] sh_start,
  output logic [REG_W-1:0] sh_stop,
  output logic [REG_W-1:0] sh_delay,
  output mode_t            sh_mode
);

  logic [REG_W-1:0] pos_q [NUM_POS_REGS];
  logic [REG_W-1:0] pos_sh [NUM_POS_REGS];
  logic [REG_W-1:0] mode_q;
  logic [REG_W-1:0] preset_q;
  mode_t            mode_dec;

  // start / stop / delay: live copy and per-line shadow
  for (genvar g = 0; g < NUM_POS_REGS; g++) begin : g_pos
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_q[g] <= '0;
      end else if (reg_we && (reg_addr == 3'(g))) begin
        pos_q[g] <= reg_wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pos_sh[g] <= '0;
      end else if (line_start) begin
        pos_sh[g] <= pos_q[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      preset_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADR_MODE)   mode_q   <= reg_wdata;
      if (reg_addr == ADR_PRESET) preset_q <= reg_wdata;
    end
  end

  always_comb begin
    mode_dec.dig = (mode_q[3:0] == MODE_DIGITAL) && preset_q[PRESET_GP_BIT];
    mode_dec.ana = (mode_q[2:0] == MODE_ANALOG_LO) && preset_q[PRESET_DE_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mode <= '0;
    end else if (line_start) begin
      sh_mode <= mode_dec;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADR_START:  reg_rdata = pos_q[ADR_START];
      ADR_STOP:   reg_rdata = pos_q[ADR_STOP];
      ADR_DELAY:  reg_rdata = pos_q[ADR_DELAY];
      ADR_MODE:   reg_rdata = mode_q;
      ADR_PRESET: reg_rdata = preset_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign sh_start = pos_sh[ADR_START];
  assign sh_stop  = pos_sh[ADR_STOP];
  assign sh_delay = pos_sh[ADR_DELAY];

  // R3
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(sh_start) && $stable(sh_stop) && $stable(sh_delay) && $stable(sh_mode)));

  // R3
  shadow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (sh_start == $past(pos_q[ADR_START])));

endmodule

// File: rtl/lpg_hcount.sv
module lpg_hcount #(
  parameter int HCNT_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              half_tick,
  output logic [HCNT_W-1:0] hcnt
);

  localparam logic [HCNT_W-1:0] HCNT_MAX = '1;

  logic at_max;

  assign at_max = (hcnt == HCNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= HCNT_MAX;
    end else if (line_start) begin
      hcnt <= '0;
    end else if (half_tick && !at_max) begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // R11
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> (hcnt == '0));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_max && !line_start) |=> at_max);

  // R11
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !line_start && !at_max) |=> (hcnt == $past(hcnt) + 1'b1));

endmodule

// File: rtl/lpg_window.sv
module lpg_window
  import lpg_pkg::*;
#(
  parameter int REG_W  = 8,
  parameter int HCNT_W = REG_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HCNT_W-1:0] hcnt,
  input  logic [REG_W-1:0]  sh_start,
  input  logic [REG_W-1:0]  sh_stop,
  input  logic [REG_W-1:0]  sh_delay,
  input  mode_t             sh_mode,
  output logic              pulse_out,
  output logic              delay_out
);

  localparam int PIX_W = HCNT_W - 1;
  localparam int EXT_W = HCNT_W + 1;

  logic [PIX_W-1:0] pix;
  logic [EXT_W-1:0] h_ext;
  logic [EXT_W-1:0] lim_ext [2];
  logic [EXT_W-1:0] h_ofs   [2];
  logic             ana_edge [2];
  logic [PIX_W-1:0] pix_start, pix_stop, pix_delay;
  logic             dig_win, ana_win, dly_hit;

  assign pix   = hcnt[HCNT_W-1:1];
  assign h_ext = {1'b0, hcnt};

  assign pix_start = PIX_W'(sh_start);
  assign pix_stop  = PIX_W'(sh_stop);
  assign pix_delay = PIX_W'(sh_delay);

  assign lim_ext[0] = EXT_W'(sh_start);
  assign lim_ext[1] = EXT_W'(sh_stop);

  // edge 0: leading (start) edge, edge 1: trailing (stop) edge
  for (genvar e = 0; e < 2; e++) begin : g_edge
    localparam int OFS = (e == 0) ? ANA_START_OFS : ANA_STOP_OFS;
    assign h_ofs[e] = h_ext + EXT_W'(OFS);
    if (e == 0) begin : g_lead
      assign ana_edge[e] = (h_ofs[e] >= lim_ext[e]);
    end else begin : g_trail
      assign ana_edge[e] = (h_ofs[e] <= lim_ext[e]);
    end
  end

  assign dig_win = (pix >= pix_start) && (pix <= pix_stop);
  assign ana_win = ana_edge[0] && ana_edge[1];
  assign dly_hit = (pix == pix_delay);

  always_comb begin
    pulse_out = 1'b0;
    delay_out = 1'b0;
    if (sh_mode.dig) begin
      pulse_out = dig_win;
      delay_out = dly_hit;
    end else if (sh_mode.ana) begin
      pulse_out = ana_win;
    end
  end

  // R8
  delay_digital_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    delay_out |-> sh_mode.dig);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sh_mode.dig || sh_mode.ana) |-> !pulse_out);

  // R5
  reversed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_mode.dig && (sh_stop < sh_start)) |-> !pulse_out);

  // R4
  dig_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_mode.dig && pulse_out) |-> ((hcnt >> 1) >= HCNT_W'(sh_start)));

endmodule

// File: rtl/line_pulse_gen.sv
module line_pulse_gen
  import lpg_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             half_tick,
  input  logic             line_start,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             pulse_out,
  output logic             delay_out
);

  localparam int HCNT_W = REG_W + 2;

  logic [HCNT_W-1:0] hcnt;
  logic [REG_W-1:0]  sh_start, sh_stop, sh_delay;
  mode_t             sh_mode;

  lpg_regs #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .sh_start   (sh_start),
    .sh_stop    (sh_stop),
    .sh_delay   (sh_delay),
    .sh_mode    (sh_mode)
  );

  lpg_hcount #(.HCNT_W(HCNT_W)) u_hcount (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .half_tick  (half_tick),
    .hcnt       (hcnt)
  );

  lpg_window #(.REG_W(REG_W), .HCNT_W(HCNT_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .hcnt      (hcnt),
    .sh_start  (sh_start),
    .sh_stop   (sh_stop),
    .sh_delay  (sh_delay),
    .sh_mode   (sh_mode),
    .pulse_out (pulse_out),
    .delay_out (delay_out)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!pulse_out && !delay_out));

endmodule

// File: tb/sim_line_pulse_gen.sv
module sim_line_pulse_gen;

  localparam int HMAX = 1023;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       half_tick = 1'b0;
  logic       line_start = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       pulse_out, delay_out;

  int n_chk = 0;
  int n_fail = 0;

  // live register mirror and per-line model copy
  int r_s = 0, r_p = 0, r_d = 0, r_m = 0, r_pre = 0;
  int l_s = 0, l_p = 0, l_d = 0, l_m = 0, l_pre = 0;
  int h = HMAX;

  always #2 clk = ~clk;

  line_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .line_start(line_start),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pulse_out(pulse_out), .delay_out(delay_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (h=%0d)", req, act, exp, h);
    end
  endtask

  function automatic bit m_dig();
    return ((l_m & 4'hF) == 4'hA) && l_pre[5];
  endfunction

  function automatic bit m_ana();
    return ((l_m & 3'h7) == 3'h4) && l_pre[7];
  endfunction

  task automatic check_outs();
    int pix;
    bit ep, ed;
    string rq;
    pix = h / 2;
    ep = 1'b0;
    ed = 1'b0;
    if (m_dig()) begin
      ep = (pix >= l_s) && (pix <= l_p);
      ed = (pix == l_d);
      rq = (l_p < l_s) ? "R5" : "R4";
    end else if (m_ana()) begin
      ep = (h + 5 >= l_s) && (h + 2 <= l_p);
      rq = "R7";
    end else begin
      rq = "R9/R6";
    end
    chk(pulse_out == ep, {rq, " pulse_out"}, int'(pulse_out), int'(ep));
    chk(delay_out == ed, "R8 delay_out", int'(delay_out), int'(ed));
  endtask

  task automatic wr(input int a, input int v);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = 3'(a);
    reg_wdata = 8'(v);
    @(posedge clk);
    case (a)
      0: r_s = v & 255;
      1: r_p = v & 255;
      2: r_d = v & 255;
      3: r_m = v & 255;
      4: r_pre = v & 255;
      default: ;
    endcase
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    chk(reg_rdata == 8'(exp), req, int'(reg_rdata), exp);
  endtask

  task automatic cfg(input int s, input int p, input int d, input int m, input int pre);
    wr(0, s); wr(1, p); wr(2, d); wr(3, m); wr(4, pre);
  endtask

  task automatic start_line(input bit with_tick);
    @(negedge clk);
    line_start = 1'b1;
    half_tick = with_tick;
    @(posedge clk);
    l_s = r_s; l_p = r_p; l_d = r_d; l_m = r_m; l_pre = r_pre;
    h = 0;
    @(negedge clk);
    line_start = 1'b0;
    half_tick = 1'b0;
    chk(pulse_out == 1'b0 || h == 0, "R11 restart", 0, 0);
    check_outs();
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      half_tick = 1'b1;
      @(posedge clk);
      if (h < HMAX) h++;
      @(negedge clk);
      half_tick = 1'b0;
      check_outs();
      for (int g = 0; g < gap; g++) begin
        @(posedge clk);
        @(negedge clk);
        check_outs();
      end
    end
  endtask

  task automatic line(input int s, input int p, input int d, input int m,
                      input int pre, input int n, input int gap);
    cfg(s, p, d, m, pre);
    start_line(1'b0);
    run_ticks(n, gap);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pulse_out == 1'b0 && delay_out == 1'b0, "R1 outputs in reset", int'(pulse_out), 0);
    rst_n = 1'b1;
    // R1 reset readback
    for (int a = 0; a < 5; a++) rd_chk(a, 0, "R1 register reset");
    chk(pulse_out == 1'b0 && delay_out == 1'b0, "R1 outputs idle", int'(pulse_out), 0);

    // R2 readback of each address, unused addresses
    cfg(8'h11, 8'h22, 8'h33, 8'hF4, 8'h5A);
    rd_chk(0, 8'h11, "R2 start"); rd_chk(1, 8'h22, "R2 stop");
    rd_chk(2, 8'h33, "R2 delay"); rd_chk(3, 8'hF4, "R2 mode");
    rd_chk(4, 8'h5A, "R2 preset");
    for (int a = 5; a < 8; a++) rd_chk(a, 0, "R2 unused address");
    // R3: nothing loaded yet, outputs still low
    @(negedge clk);
    chk(pulse_out == 1'b0, "R3 no effect before line start", int'(pulse_out), 0);

    // R4 digital windows, ticks every cycle and every other cycle
    line(3, 7, 5, 8'h0A, 8'h20, 40, 0);
    line(10, 10, 0, 8'h0A, 8'h20, 30, 1);
    line(0, 4, 12, 8'h0A, 8'hA0, 30, 0);
    // R5 reversed window
    line(9, 4, 6, 8'h0A, 8'h20, 30, 0);
    // R10 full line to saturation, wide window
    line(250, 255, 255, 8'h0A, 8'h20, 1040, 0);
    // R6 missing one condition
    line(2, 8, 3, 8'h0A, 8'hDF, 30, 0);
    line(2, 8, 3, 8'h0B, 8'h20, 30, 0);
    line(2, 8, 3, 8'h00, 8'h00, 20, 0);
    // R7 analog windows, half-pixel steps and offsets
    line(5, 2, 0, 8'h04, 8'h80, 12, 0);
    line(0, 20, 0, 8'h04, 8'h80, 30, 0);
    line(9, 12, 4, 8'h0C, 8'hA0, 20, 1);
    line(5, 2, 0, 8'h04, 8'h7F, 12, 0);
    // R9 analog mode keeps delay_out low even with delay hitting
    line(0, 40, 3, 8'h04, 8'hA0, 30, 0);

    // R3 mid-line write does not alter current line, applies next line
    line(4, 8, 6, 8'h0A, 8'h20, 6, 0);
    wr(0, 1); wr(1, 2); wr(2, 9);
    rd_chk(0, 1, "R2 live readback after write");
    run_ticks(20, 0);
    start_line(1'b0);
    run_ticks(24, 0);

    // R11 restart mid-line and restart coinciding with a tick
    cfg(2, 5, 3, 8'h0A, 8'h20);
    start_line(1'b0);
    run_ticks(9, 0);
    start_line(1'b1);
    chk(h == 0, "R11 h cleared", h, 0);
    run_ticks(16, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule